// File: doc/BRIEF.md
# Comparator Event Timer Channel

This block is a single channel of a multi-channel event timer. A shared free-running main counter is fed in from outside. The channel compares that count against its own comparator and emits a one-cycle `fire` strobe when the two agree. Software programs the channel through three decoded 32-bit write strobes: one for the configuration word and one for each half of the comparator. The configuration word and the comparator can be read back at any time.

The channel runs in one of two modes. In one-shot mode it fires once at the programmed count. In periodic mode it fires and then moves its comparator forward by a hidden period register. In periodic mode a comparator write loads that period, and it also loads the comparator itself only when a self-clearing set-value flag is armed. A 32-bit mode truncates the comparator and the period and compares only the low word of the counter. In 32-bit one-shot mode, if the low word would roll over before the match, the channel gives an extra event at the rollover and then fires again at the real match.

Configuration word layout: bit 0 timer enable, bit 1 periodic, bit 2 set-value, bit 3 32-bit mode, bit 4 periodic-capable (reads 1), bit 5 64-bit-capable (reads 1), bits 31:6 read 0, bits 63:32 hold the read-only route capability parameter.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset the comparator reads all ones, the period is 0, and the configuration reads back with bits 3:0 clear and bits 5:4 set.
- R2: `fire` is high in the cycle after each clock edge at which the active channel's comparator equals the main counter, and low otherwise.
- R3: The channel fires only while both the timer enable bit (bit 0) and `global_en` are 1.
- R4: In periodic mode a comparator write loads the period, and it loads the comparator only if set-value (bit 2) is 1. Every comparator write clears set-value.
- R5: In periodic mode with a non-zero period, a match moves the comparator forward by the period.
- R6: In periodic mode, when the comparator is behind the counter (negative signed difference), it is advanced by the period once per cycle without firing until it is no longer behind.
- R7: Every period value written in periodic mode has its top bit forced to 0: bit 31 of the low write in 32-bit mode, and bit 63 through the high write in 64-bit mode.
- R8: Selecting 32-bit mode (bit 3) clears the upper words of the comparator and the period. In that mode, comparator high writes are ignored, matching uses only the low 32 bits of the counter, and period advances wrap at 32 bits.
- R9: In 32-bit one-shot mode, arming with a comparator whose distance from the counter exceeds the distance to low-word rollover makes the channel fire at low word 0xFFFFFFFF first, then again at the match.
- R10: Clearing the enable bit stops all firing. Setting it again re-arms the channel.
- R11: Configuration bits 63:32 always read the route capability parameter and cannot be written. Only bits 3:0 are writable.
- R12: A comparator write re-arms the channel and recomputes the rollover flag, so an earlier pending rollover event is dropped if the new distance no longer needs it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| main_count | input | 64 | Shared main counter value |
| global_en | input | 1 | Global enable of the timer block |
| cfg_wr | input | 1 | Write strobe for the configuration low word |
| cmp_lo_wr | input | 1 | Write strobe for the comparator low word |
| cmp_hi_wr | input | 1 | Write strobe for the comparator high word |
| wr_data | input | 32 | Write data for the strobed register |
| fire | output | 1 | One-cycle event strobe |
| cfg_rd | output | 64 | Configuration readback |
| cmp_rd | output | 64 | Comparator readback |

## Verification
The hardest situation to reach is the pending rollover event in 32-bit one-shot mode. It needs the counter's low word parked just below 0xFFFFFFFF while the timer is armed with a small comparator value, then the counter walked across the rollover. The bench drives the main counter directly instead of letting it count, so it can jump to those spots. It then re-writes the comparator while the rollover is still pending, to show that the flag is recomputed. The silent catch-up of a periodic comparator is reached in the same way, by jumping the counter far past the comparator and then watching the comparator readback settle.

// File: rtl/evt_tmr_pkg.sv
package evt_tmr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 2 * WORD_W;
    localparam int unsigned MODE_W = 4;
    localparam logic [1:0]  CAP_BITS = 2'b11;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [CNT_W-1:0]  count_t;

    // Writable mode bits, in configuration bit order 3..0
    typedef struct packed {
        logic narrow;
        logic set_val;
        logic periodic;
        logic enable;
    } mode_t;

    // Target lies behind now on a 32-bit circular scale
    function automatic logic word_behind(word_t target, word_t now);
        word_t d;
        d = target - now;
        return d[WORD_W-1];
    endfunction

    // Target lies behind now on a 64-bit circular scale
    function automatic logic count_behind(count_t target, count_t now);
        count_t d;
        d = target - now;
        return d[CNT_W-1];
    endfunction

    // Low word rolls over before it reaches the target
    function automatic logic wrap_comes_first(word_t target, word_t now);
        word_t d;
        word_t gap;
        d   = target - now;
        gap = ~now;
        if (d[WORD_W-1] || (d == '0)) begin
            return 1'b0;
        end
        return gap < d;
    endfunction

    // Period values are limited to half the counter range
    function automatic word_t cap_top(word_t v);
        return {1'b0, v[WORD_W-2:0]};
    endfunction

endpackage

// File: rtl/evt_tmr_cfg.sv
module evt_tmr_cfg
    import evt_tmr_pkg::*;
#(
    parameter logic [WORD_W-1:0] ROUTE_CAP = 32'h0000_0004
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cfg_wr,
    input  logic [MODE_W-1:0]  mode_wdata,
    input  logic               clr_set_val,
    output mode_t              mode,
    output logic               en_rise,
    output logic               en_fall,
    output logic [CNT_W-1:0]   cfg_rd
);

    localparam int unsigned PAD_W = WORD_W - MODE_W - 2;

    mode_t mode_q;
    mode_t mode_new;

    assign mode_new = mode_t'(mode_wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= '0;
        end else if (cfg_wr) begin
            mode_q <= mode_new;
        end else if (clr_set_val) begin
            mode_q.set_val <= 1'b0;
        end
    end

    assign en_rise = cfg_wr &&  mode_new.enable && !mode_q.enable;
    assign en_fall = cfg_wr && !mode_new.enable &&  mode_q.enable;
    assign mode    = mode_q;
    assign cfg_rd  = {ROUTE_CAP, {PAD_W{1'b0}}, CAP_BITS, mode_q};

endmodule

// File: rtl/evt_tmr_cmp.sv
module evt_tmr_cmp
    import evt_tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   periodic,
    input  logic   set_val,
    input  logic   narrow,
    input  logic   narrow_sel,
    input  logic   cmp_lo_wr,
    input  logic   cmp_hi_wr,
    input  word_t  wr_data,
    input  logic   advance,
    output count_t cmp_q,
    output count_t period_q,
    output logic   cmp_written
);

    logic [1:0] lane_wr;
    logic       load_cmp;

    assign lane_wr[0]  = cmp_lo_wr;
    assign lane_wr[1]  = cmp_hi_wr && !narrow;
    assign load_cmp    = !periodic || set_val;
    assign cmp_written = |lane_wr;

    // One lane per comparator half; the top bit of a period write is capped
    for (genvar h = 0; h < 2; h++) begin : g_lane
        localparam bit TOP = (h == 1);
        word_t period_wdata;
        assign period_wdata = (TOP || narrow) ? cap_top(wr_data) : wr_data;

        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_q[h*WORD_W +: WORD_W]    <= '1;
                period_q[h*WORD_W +: WORD_W] <= '0;
            end else if (narrow_sel && TOP) begin
                cmp_q[h*WORD_W +: WORD_W]    <= '0;
                period_q[h*WORD_W +: WORD_W] <= '0;
            end else if (lane_wr[h]) begin
                if (load_cmp) begin
                    cmp_q[h*WORD_W +: WORD_W] <= wr_data;
                end
                if (periodic) begin
                    period_q[h*WORD_W +: WORD_W] <= period_wdata;
                end
            end else if (advance && !cmp_written && !narrow_sel) begin
                if (narrow) begin
                    cmp_q[h*WORD_W +: WORD_W] <= TOP ? '0 :
                        cmp_q[WORD_W-1:0] + period_q[WORD_W-1:0];
                end else begin
                    cmp_q[h*WORD_W +: WORD_W] <= next_wide[h*WORD_W +: WORD_W];
                end
            end
        end
    end

    count_t next_wide;
    assign next_wide = cmp_q + period_q;

endmodule

// File: rtl/evt_tmr_match.sv
module evt_tmr_match
    import evt_tmr_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  count_t main_count,
    input  logic   global_en,
    input  logic   enable,
    input  logic   periodic,
    input  logic   narrow,
    input  count_t cmp_q,
    input  count_t period_q,
    input  logic   en_rise,
    input  logic   en_fall,
    input  logic   cmp_written,
    output logic   advance,
    output logic   fire
);

    logic  active;
    logic  equal;
    logic  behind;
    logic  has_period;
    logic  wrap_hit;
    logic  wrap_q;
    logic  rearm_q;
    logic  gen_prev_q;
    logic  fire_q;
    word_t cnt_lo;
    word_t cmp_lo;

    assign cnt_lo     = main_count[WORD_W-1:0];
    assign cmp_lo     = cmp_q[WORD_W-1:0];
    assign active     = enable && global_en;
    assign equal      = narrow ? (cnt_lo == cmp_lo) : (main_count == cmp_q);
    assign behind     = narrow ? word_behind(cmp_lo, cnt_lo)
                               : count_behind(cmp_q, main_count);
    assign has_period = (period_q != '0);
    assign advance    = active && periodic && has_period && (equal || behind);
    assign wrap_hit   = active && wrap_q && (cnt_lo == '1);

    always_ff @(posedge clk) begin
        if (rst) begin
            gen_prev_q <= 1'b0;
            rearm_q    <= 1'b0;
            wrap_q     <= 1'b0;
            fire_q     <= 1'b0;
        end else begin
            gen_prev_q <= global_en;
            rearm_q    <= en_rise || cmp_written || (global_en && !gen_prev_q);
            fire_q     <= active && (equal || wrap_hit);
            if (en_rise || en_fall || cmp_written) begin
                wrap_q <= 1'b0;
            end else if (rearm_q) begin
                wrap_q <= enable && narrow && !periodic &&
                          wrap_comes_first(cmp_lo, cnt_lo);
            end else if (wrap_hit) begin
                wrap_q <= 1'b0;
            end
        end
    end

    assign fire = fire_q;

endmodule

// File: rtl/evt_timer_channel.sv
module evt_timer_channel
    import evt_tmr_pkg::*;
#(
    parameter logic [31:0] ROUTE_CAP = 32'h0000_0004
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [63:0] main_count,
    input  logic        global_en,
    input  logic        cfg_wr,
    input  logic        cmp_lo_wr,
    input  logic        cmp_hi_wr,
    input  logic [31:0] wr_data,
    output logic        fire,
    output logic [63:0] cfg_rd,
    output logic [63:0] cmp_rd
);

    mode_t  mode;
    logic   en_rise;
    logic   en_fall;
    logic   cmp_written;
    logic   advance;
    logic   narrow_sel;
    count_t cmp_q;
    count_t period_q;

    assign narrow_sel = cfg_wr && wr_data[3];

    evt_tmr_cfg #(.ROUTE_CAP(ROUTE_CAP)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (cfg_wr),
        .mode_wdata  (wr_data[MODE_W-1:0]),
        .clr_set_val (cmp_written),
        .mode        (mode),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .cfg_rd      (cfg_rd)
    );

    evt_tmr_cmp u_cmp (
        .clk         (clk),
        .rst         (rst),
        .periodic    (mode.periodic),
        .set_val     (mode.set_val),
        .narrow      (mode.narrow),
        .narrow_sel  (narrow_sel),
        .cmp_lo_wr   (cmp_lo_wr),
        .cmp_hi_wr   (cmp_hi_wr),
        .wr_data     (wr_data),
        .advance     (advance),
        .cmp_q       (cmp_q),
        .period_q    (period_q),
        .cmp_written (cmp_written)
    );

    evt_tmr_match u_match (
        .clk         (clk),
        .rst         (rst),
        .main_count  (main_count),
        .global_en   (global_en),
        .enable      (mode.enable),
        .periodic    (mode.periodic),
        .narrow      (mode.narrow),
        .cmp_q       (cmp_q),
        .period_q    (period_q),
        .en_rise     (en_rise),
        .en_fall     (en_fall),
        .cmp_written (cmp_written),
        .advance     (advance),
        .fire        (fire)
    );

    assign cmp_rd = cmp_q;

endmodule

// File: rtl/evt_tmr_chk.sv
module evt_tmr_chk (
    input logic        clk,
    input logic        rst,
    input logic        global_en,
    input logic        cfg_wr,
    input logic        cmp_lo_wr,
    input logic [31:0] wr_data,
    input logic        fire,
    input logic [63:0] cfg_rd,
    input logic [63:0] cmp_rd
);

    // R1: state right after reset
    a_r1_reset_state: assert property (@(posedge clk)
        ($past(rst) && !rst) |-> (cmp_rd == '1 && cfg_rd[3:0] == 4'h0));

    // R3: a fire needs both enables at the edge that produced it
    a_r3_fire_needs_enables: assert property (@(posedge clk) disable iff (rst)
        fire |-> $past(cfg_rd[0] && global_en));

    // R4: set-value clears after a comparator write
    a_r4_setval_clears: assert property (@(posedge clk) disable iff (rst)
        (cmp_lo_wr && !cfg_wr) |=> !cfg_rd[2]);

    // R8: upper comparator word is zero in 32-bit mode
    a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
        cfg_rd[3] |-> (cmp_rd[63:32] == 32'h0));

    // R10: no fire once the enable has been cleared
    a_r10_disable_quiet: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !wr_data[0]) |-> ##2 !fire);

endmodule

bind evt_timer_channel evt_tmr_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .global_en (global_en),
    .cfg_wr    (cfg_wr),
    .cmp_lo_wr (cmp_lo_wr),
    .wr_data   (wr_data),
    .fire      (fire),
    .cfg_rd    (cfg_rd),
    .cmp_rd    (cmp_rd)
);

// File: tb/test_evt_timer_channel.sv
`timescale 1ns/1ps
module test_evt_timer_channel;

    localparam logic [31:0] CAP = 32'h0000_0004;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] main_count = '0;
    logic        global_en = 1'b0;
    logic        cfg_wr = 1'b0;
    logic        cmp_lo_wr = 1'b0;
    logic        cmp_hi_wr = 1'b0;
    logic [31:0] wr_data = '0;
    logic        fire;
    logic [63:0] cfg_rd;
    logic [63:0] cmp_rd;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    evt_timer_channel #(.ROUTE_CAP(CAP)) i_evt_timer_channel (
        .clk(clk), .rst(rst), .main_count(main_count), .global_en(global_en),
        .cfg_wr(cfg_wr), .cmp_lo_wr(cmp_lo_wr), .cmp_hi_wr(cmp_hi_wr),
        .wr_data(wr_data), .fire(fire), .cfg_rd(cfg_rd), .cmp_rd(cmp_rd)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic at_count(input logic [63:0] v);
        main_count = v;
        step();
    endtask

    task automatic wr(input int kind, input logic [31:0] d);
        wr_data   = d;
        cfg_wr    = (kind == 0);
        cmp_lo_wr = (kind == 1);
        cmp_hi_wr = (kind == 2);
        step();
        cfg_wr = 1'b0; cmp_lo_wr = 1'b0; cmp_hi_wr = 1'b0;
        step();
    endtask

    task automatic do_reset();
        rst = 1'b1; global_en = 1'b0; main_count = '0;
        repeat (3) step();
        rst = 1'b0;
        step();
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 cmp", cmp_rd, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R1 cfg", cfg_rd, {CAP, 32'h30});
        check("R1 fire", {63'd0, fire}, 64'd0);
    endtask

    task automatic t_oneshot();
        do_reset();
        global_en = 1'b1;
        wr(1, 32'd100); wr(2, 32'd0); wr(0, 32'h1);
        at_count(64'd99);  check("R2 before", {63'd0, fire}, 64'd0);
        at_count(64'd100); check("R2 match", {63'd0, fire}, 64'd1);
        at_count(64'd101); check("R2 after", {63'd0, fire}, 64'd0);
        global_en = 1'b0;
        at_count(64'd100); check("R3 global off", {63'd0, fire}, 64'd0);
        global_en = 1'b1;
        at_count(64'd0);
        at_count(64'd100); check("R3 global on", {63'd0, fire}, 64'd1);
    endtask

    task automatic t_periodic();
        int fires;
        do_reset();
        global_en = 1'b1;
        wr(0, 32'h6); wr(2, 32'd0);
        wr(0, 32'h6); wr(1, 32'd200);
        check("R4 setval cleared", {63'd0, cfg_rd[2]}, 64'd0);
        check("R4 cmp loaded", cmp_rd, 64'd200);
        wr(1, 32'd50);
        check("R4 cmp kept", cmp_rd, 64'd200);
        wr(0, 32'h3);
        at_count(64'd200); check("R5 fire", {63'd0, fire}, 64'd1);
        check("R5 advance", cmp_rd, 64'd250);
        at_count(64'd201); check("R5 quiet", {63'd0, fire}, 64'd0);
        at_count(64'd250); check("R5 second", cmp_rd, 64'd300);
        main_count = 64'd1010;
        fires = 0;
        for (int i = 0; i < 20; i++) begin
            step();
            if (fire) fires++;
        end
        check("R6 catch-up", cmp_rd, 64'd1050);
        check("R6 silent", fires, 64'd0);
    endtask

    task automatic t_narrow_periodic();
        do_reset();
        global_en = 1'b1;
        wr(0, 32'h8);
        check("R8 truncate", cmp_rd, 64'h0000_0000_FFFF_FFFF);
        wr(2, 32'h1234);
        check("R8 high ignored", cmp_rd, 64'h0000_0000_FFFF_FFFF);
        wr(0, 32'hE); wr(1, 32'hFFFF_FFFF);
        at_count(64'hFFFF_FF00);
        wr(0, 32'hB);
        at_count(64'hFFFF_FFFF); check("R7 fire", {63'd0, fire}, 64'd1);
        check("R7 capped period", cmp_rd, 64'h0000_0000_7FFF_FFFE);
        at_count(64'h5_7FFF_FFFE); check("R8 low-word match", {63'd0, fire}, 64'd1);
        check("R8 32-bit wrap", cmp_rd, 64'h0000_0000_FFFF_FFFD);
    endtask

    task automatic t_wrap();
        do_reset();
        global_en = 1'b1;
        at_count(64'hFFFF_FFF0);
        wr(0, 32'h8); wr(1, 32'h10); wr(0, 32'h9);
        at_count(64'hFFFF_FFFF);   check("R9 wrap event", {63'd0, fire}, 64'd1);
        at_count(64'h1_0000_0000); check("R9 quiet", {63'd0, fire}, 64'd0);
        at_count(64'h1_0000_0010); check("R9 real match", {63'd0, fire}, 64'd1);
        at_count(64'h2_FFFF_FFF0);
        wr(1, 32'h10);
        wr(1, 32'hFFFF_FFF8);
        at_count(64'h2_FFFF_FFFF); check("R12 wrap dropped", {63'd0, fire}, 64'd0);
        at_count(64'h2_FFFF_FFF8); check("R12 match", {63'd0, fire}, 64'd1);
    endtask

    task automatic t_disable();
        do_reset();
        global_en = 1'b1;
        wr(1, 32'd500); wr(2, 32'd0); wr(0, 32'h1); wr(0, 32'h0);
        at_count(64'd500); check("R10 disabled", {63'd0, fire}, 64'd0);
        at_count(64'd0);
        wr(0, 32'h1);
        at_count(64'd500); check("R10 re-armed", {63'd0, fire}, 64'd1);
    endtask

    task automatic t_cfg_ro();
        do_reset();
        wr(0, 32'hFFFF_FFFF);
        check("R11 all ones", cfg_rd, {CAP, 32'h3F});
        wr(0, 32'h0);
        check("R11 zeros", cfg_rd, {CAP, 32'h30});
    endtask

    initial begin
        t_reset();
        t_oneshot();
        t_periodic();
        t_narrow_periodic();
        t_wrap();
        t_disable();
        t_cfg_ro();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule